// File: doc/BRIEF.md
# Decomposed-Reward SARSA Tuning Agent

This block is an online learning agent that picks one setting of a memory controller knob (for instance the page policy) at the end of every statistics window. It learns from seven per-metric rewards. Each metric has its own Q-table indexed by state and candidate action. The state is the action that was in force during the previous window. Keeping the tables apart lets software inspect why one action beats another, one metric at a time. The agent chooses the next action by epsilon-greedy selection over the sum of the per-metric Q-values. It then applies an on-policy (SARSA) update to every table.

A metrics unit presents the observed values and the target values of the seven metrics and pulses `win_done`. The agent then runs a short multi-cycle sequence with `busy` high. It computes the seven rewards one per cycle through a shared divider, selects the next action, and updates one table per cycle. It finally drives the new action with a one-cycle `act_done` pulse. It also keeps a running sum of the total reward over windows past the warm-up count.

Top module: `sarsa_tune_agent`

## Requirements
- R1: After reset `act_sel` is 0, `cum_reward` is 0, `busy` is 0 and `act_done` is 0; every Q entry is 0 and the generator holds `BASE_SEED + AGENT_ID` (1 if that sum is zero).
- R2: The reward of metric c is floor(target·2^16 / |target − observed|) as a signed 16.16 value (metrics are unsigned `MET_W`-bit integers; metric c sits in bits [c·MET_W +: MET_W] of each input vector). The reward saturates to 0x7FFF_FFFF when the difference is zero or the quotient exceeds that value.
- R3: The step reward is the sum of the seven metric rewards. Windows are numbered from 1. The step reward is added to `cum_reward` only in windows whose number is at least `WARMUP`, so `cum_reward` never decreases.
- R4: For every metric c, Q[c][s][a] becomes sat32(Q + floor(6554·(r_c + floor(58982·Q[c][a][a']/2^16) − Q)/2^16)). Here s is the state, a the applied action and a' the newly chosen action; 6554 and 58982 are alpha 0.1 and gamma 0.9 in 16.16. Each product is shifted arithmetically (toward minus infinity), and the result saturates to the signed 32-bit range. The entry Q[c][a][a'] is read before the write.
- R5: When not exploring, the next action is the one with the largest sum over metrics of Q[c][s][x], read at the current state s. Ties go to the lowest action index.
- R6: The exploration draw is the 32-bit generator value held before this window's step. The generator is a right-shifting Galois register: next = (v >> 1) XOR (v[0] ? 0x8020_0003 : 0). It steps once per window. The agent explores when the draw is below `EPS_OLD` in windows numbered below `WARMUP`, and below `EPS_NEW` from then on. The random action is draw mod `NUM_ACT`.
- R7: After a window the state becomes the action that was applied during it, and `act_sel` becomes the chosen action.
- R8: A `win_done` pulse seen while idle raises `busy` on the next cycle for 2·`NUM_COMP`+1 cycles. `act_sel` changes only in the cycle `act_done` is high, and `busy` is then low. A `win_done` seen while busy is ignored: no extra `act_done` and no effect on learning.
- R9: Observed and target values are captured in the cycle `win_done` is accepted; later changes during the sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_done | input | 1 | End-of-window strobe |
| obs_vals | input | NUM_COMP·MET_W | Observed metric values, metric c at [c·MET_W +: MET_W] |
| tgt_vals | input | NUM_COMP·MET_W | Target metric values, same packing |
| act_sel | output | log2(NUM_ACT) | Currently selected action |
| act_done | output | 1 | One-cycle pulse when a new action is in place |
| busy | output | 1 | Sequence in progress |
| cum_reward | output | CUM_W | Cumulative 16.16 reward after warm-up |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of faulty design. A target equal to its observation must saturate the reward; a design that divided anyway would corrupt the cumulative sum. Observations above the target must still give a positive reward through the absolute difference. Windows just before and at the warm-up count separate a design that accumulates too early or switches epsilon at the wrong window. An all-zero table starts every greedy choice tied, so a wrong tie-break or a misread state shows up as a wrong action. A second strobe while busy would, in a faulty design, add an extra pulse and shift every later expected action and sum. Inputs changed mid-sequence would leak into the rewards of a design that does not capture them.

// File: rtl/agent_pkg.sv
package agent_pkg;

    localparam logic [31:0] FX_ALPHA = 32'd6554;
    localparam logic [31:0] FX_GAMMA = 32'd58982;
    localparam logic [31:0] FX_MAX   = 32'h7FFF_FFFF;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_REW,
        PH_SEL,
        PH_UPD
    } phase_e;

    // multiply a wide signed value by an unsigned 16.16 constant, floor shift
    function automatic logic signed [63:0] fx_scale(input logic signed [63:0] a,
                                                    input logic [31:0] k);
        logic signed [63:0] p;
        p = a * $signed({32'd0, k});
        return p >>> 16;
    endfunction

    function automatic logic [31:0] fx_sat(input logic signed [63:0] a);
        if (a > 64'sh0000_0000_7FFF_FFFF)
            return 32'h7FFF_FFFF;
        else if (a < -64'sh0000_0000_8000_0000)
            return 32'h8000_0000;
        else
            return a[31:0];
    endfunction

endpackage

// File: rtl/agent_lfsr.sv
module agent_lfsr #(
    parameter logic [31:0] SEED = 32'h1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    output logic [31:0] value
);
    localparam logic [31:0] TAPS      = 32'h8020_0003;
    localparam logic [31:0] SAFE_SEED = (SEED == 32'd0) ? 32'd1 : SEED;

    logic [31:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (step)
            lfsr_d = (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : 32'd0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SAFE_SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign value = lfsr_q;

    p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (value != $past(value)));
endmodule

// File: rtl/agent_reward_div.sv
module agent_reward_div #(
    parameter int MET_W = 16
) (
    input  logic [MET_W-1:0] tgt,
    input  logic [MET_W-1:0] obs,
    output logic [31:0]      rew
);
    import agent_pkg::*;

    logic [MET_W-1:0] diff;
    logic [63:0]      num;
    logic [63:0]      quo;

    always_comb begin
        diff = (tgt >= obs) ? (tgt - obs) : (obs - tgt);
        num  = 64'(tgt) << 16;
        quo  = (diff == '0) ? 64'd0 : (num / 64'(diff));
        if (diff == '0 || quo > 64'(FX_MAX))
            rew = FX_MAX;
        else
            rew = quo[31:0];
    end
endmodule

// File: rtl/agent_argmax.sv
module agent_argmax #(
    parameter int NUM_ACT = 4,
    parameter int SUM_W   = 36,
    localparam int AW     = (NUM_ACT > 1) ? $clog2(NUM_ACT) : 1
) (
    input  logic [NUM_ACT-1:0][SUM_W-1:0] sums,
    output logic [AW-1:0]                 best
);
    logic signed [SUM_W-1:0] best_v;

    always_comb begin
        best   = '0;
        best_v = $signed(sums[0]);
        for (int a = 1; a < NUM_ACT; a++) begin
            if ($signed(sums[a]) > best_v) begin
                best_v = $signed(sums[a]);
                best   = AW'(a);
            end
        end
    end
endmodule

// File: rtl/sarsa_tune_agent.sv
module sarsa_tune_agent #(
    parameter int          NUM_ACT   = 4,
    parameter int          NUM_COMP  = 7,
    parameter int          MET_W     = 16,
    parameter int          CUM_W     = 48,
    parameter int          WARMUP    = 16000,
    parameter logic [31:0] EPS_OLD   = 32'h3333_3333,
    parameter logic [31:0] EPS_NEW   = 32'h0041_8937,
    parameter logic [31:0] BASE_SEED = 32'hACE1_2468,
    parameter int          AGENT_ID  = 0,
    localparam int AW    = (NUM_ACT > 1) ? $clog2(NUM_ACT) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      win_done,
    input  logic [NUM_COMP*MET_W-1:0] obs_vals,
    input  logic [NUM_COMP*MET_W-1:0] tgt_vals,
    output logic [AW-1:0]             act_sel,
    output logic                      act_done,
    output logic                      busy,
    output logic [CUM_W-1:0]          cum_reward
);
    import agent_pkg::*;

    localparam int          CIW   = (NUM_COMP > 1) ? $clog2(NUM_COMP) : 1;
    localparam int          SUM_W = 32 + $clog2(NUM_COMP) + 1;
    localparam int          CNT_W = $clog2(WARMUP + 1) + 1;
    localparam logic [31:0] SEED  = BASE_SEED + 32'(AGENT_ID);

    typedef struct packed {
        phase_e                                          ph;
        logic [CIW-1:0]                                  ci;
        logic [AW-1:0]                                   st;
        logic [AW-1:0]                                   act;
        logic [AW-1:0]                                   nxt;
        logic                                            done;
        logic [NUM_COMP-1:0][MET_W-1:0]                  obs;
        logic [NUM_COMP-1:0][MET_W-1:0]                  tgt;
        logic [NUM_COMP-1:0][31:0]                       rew;
        logic [NUM_COMP-1:0][NUM_ACT-1:0][NUM_ACT-1:0][31:0] q;
        logic [CUM_W-1:0]                                cum;
        logic [CNT_W-1:0]                                cnt;
    } agent_t;

    agent_t r_d, r_q;

    logic [31:0]                      draw;
    logic [31:0]                      rew_c;
    logic [AW-1:0]                    greedy;
    logic [NUM_ACT-1:0][SUM_W-1:0]    sums;
    logic                             warm;
    logic [31:0]                      eps;
    logic [AW-1:0]                    rand_act;
    logic [CUM_W-1:0]                 total;
    logic signed [63:0]               q_old, q_nxt, td;

    agent_lfsr #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (r_q.ph == PH_SEL),
        .value (draw)
    );

    agent_reward_div #(.MET_W(MET_W)) u_div (
        .tgt (r_q.tgt[r_q.ci]),
        .obs (r_q.obs[r_q.ci]),
        .rew (rew_c)
    );

    // summed component values at the current state
    always_comb begin
        for (int a = 0; a < NUM_ACT; a++) begin
            sums[a] = '0;
            for (int c = 0; c < NUM_COMP; c++)
                sums[a] = sums[a] + {{(SUM_W-32){r_q.q[c][r_q.st][a][31]}},
                                     r_q.q[c][r_q.st][a]};
        end
    end

    agent_argmax #(.NUM_ACT(NUM_ACT), .SUM_W(SUM_W)) u_argmax (
        .sums (sums),
        .best (greedy)
    );

    always_comb begin
        warm     = (32'(r_q.cnt) + 32'd1) < 32'(WARMUP);
        eps      = warm ? EPS_OLD : EPS_NEW;
        rand_act = AW'(draw % 32'(NUM_ACT));
        total    = '0;
        for (int c = 0; c < NUM_COMP; c++)
            total = total + CUM_W'(r_q.rew[c]);
        q_old = 64'($signed(r_q.q[r_q.ci][r_q.st][r_q.act]));
        q_nxt = 64'($signed(r_q.q[r_q.ci][r_q.act][r_q.nxt]));
        td    = $signed({32'd0, r_q.rew[r_q.ci]}) + fx_scale(q_nxt, FX_GAMMA) - q_old;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (win_done) begin
                    for (int c = 0; c < NUM_COMP; c++) begin
                        r_d.obs[c] = obs_vals[c*MET_W +: MET_W];
                        r_d.tgt[c] = tgt_vals[c*MET_W +: MET_W];
                    end
                    r_d.ci = '0;
                    r_d.ph = PH_REW;
                end
            end
            PH_REW: begin
                r_d.rew[r_q.ci] = rew_c;
                if (32'(r_q.ci) == 32'(NUM_COMP - 1)) begin
                    r_d.ci = '0;
                    r_d.ph = PH_SEL;
                end else begin
                    r_d.ci = r_q.ci + 1'b1;
                end
            end
            PH_SEL: begin
                r_d.nxt = (draw < eps) ? rand_act : greedy;
                if (!warm)
                    r_d.cum = r_q.cum + total;
                if (32'(r_q.cnt) < 32'(WARMUP))
                    r_d.cnt = r_q.cnt + 1'b1;
                r_d.ph = PH_UPD;
            end
            PH_UPD: begin
                r_d.q[r_q.ci][r_q.st][r_q.act] = fx_sat(q_old + fx_scale(td, FX_ALPHA));
                if (32'(r_q.ci) == 32'(NUM_COMP - 1)) begin
                    r_d.ci   = '0;
                    r_d.st   = r_q.act;
                    r_d.act  = r_q.nxt;
                    r_d.done = 1'b1;
                    r_d.ph   = PH_IDLE;
                end else begin
                    r_d.ci = r_q.ci + 1'b1;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign act_sel    = r_q.act;
    assign act_done   = r_q.done;
    assign busy       = (r_q.ph != PH_IDLE);
    assign cum_reward = r_q.cum;

    p_cum_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cum_reward >= $past(cum_reward)));

    p_cum_warm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_SEL && warm) |=> $stable(cum_reward));

    p_state_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_done) |-> (r_q.st == $past(act_sel)));

    p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_sel) |-> act_done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        act_done |-> !busy);

    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && win_done) |=> busy);
endmodule

// File: tb/sim_sarsa_tune_agent.sv
module sim_sarsa_tune_agent;
    localparam int          CLK_NS = 10;
    localparam int          NA     = 4;
    localparam int          NC     = 7;
    localparam int          MW     = 16;
    localparam int          WU     = 4;
    localparam logic [31:0] E_OLD  = 32'h6000_0000;
    localparam logic [31:0] E_NEW  = 32'h0041_8937;
    localparam logic [31:0] SEEDB  = 32'h1234_5678;
    localparam int          AID    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              win_done = 1'b0;
    logic [NC*MW-1:0]  obs_vals = '0;
    logic [NC*MW-1:0]  tgt_vals = '0;
    logic [1:0]        act_sel;
    logic              act_done;
    logic              busy;
    logic [47:0]       cum_reward;

    int checks = 0;
    int errors = 0;
    int dones  = 0;
    int pushes = 0;
    bit ended  = 1'b0;

    int     exp_act[$];
    longint exp_cum[$];

    // reference model state
    longint      qm[NC][NA][NA];
    int          st_m, act_m, cnt_m;
    longint      cum_m;
    logic [31:0] lfsr_m;

    always #(CLK_NS/2) clk = ~clk;

    sarsa_tune_agent #(
        .NUM_ACT(NA), .NUM_COMP(NC), .MET_W(MW), .CUM_W(48), .WARMUP(WU),
        .EPS_OLD(E_OLD), .EPS_NEW(E_NEW), .BASE_SEED(SEEDB), .AGENT_ID(AID)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .win_done(win_done),
        .obs_vals(obs_vals), .tgt_vals(tgt_vals),
        .act_sel(act_sel), .act_done(act_done), .busy(busy),
        .cum_reward(cum_reward)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic longint scale(input longint a, input longint k);
        return (a * k) >>> 16;
    endfunction

    function automatic longint sat(input longint a);
        if (a > 64'sh7FFF_FFFF) return 64'sh7FFF_FFFF;
        if (a < -64'sh8000_0000) return -64'sh8000_0000;
        return a;
    endfunction

    // R2: reward from the requirement formula
    function automatic longint reward(input longint t, input longint o);
        longint d, r;
        d = (t >= o) ? t - o : o - t;
        if (d == 0) return 64'sh7FFF_FFFF;
        r = (t * 65536) / d;
        return (r > 64'sh7FFF_FFFF) ? 64'sh7FFF_FFFF : r;
    endfunction

    function automatic int pick_t(input int w, input int c);
        return 900 + 37 * c + 11 * w;
    endfunction

    function automatic int pick_o(input int w, input int c);
        int t;
        t = pick_t(w, c);
        if (c == 0 && (w % 3) == 0) return t;          // zero difference
        if (c % 2 == 1) return t + 3 + c + (w % 5);   // observed above target
        return t - 20 - 4 * c - w;
    endfunction

    task automatic model_step(input int w);
        longint rew[NC];
        longint total, best_v, s, td;
        int     nxt;
        bit     warm;
        logic [31:0] draw, eps;
        total = 0;
        for (int c = 0; c < NC; c++) begin
            rew[c] = reward(pick_t(w, c), pick_o(w, c));
            total += rew[c];
        end
        warm = (cnt_m + 1) < WU;
        eps  = warm ? E_OLD : E_NEW;
        draw = lfsr_m;
        if (draw < eps) begin
            nxt = int'(draw % NA);                    // R6
        end else begin
            nxt = 0; best_v = 0;                      // R5
            for (int a = 0; a < NA; a++) begin
                s = 0;
                for (int c = 0; c < NC; c++) s += qm[c][st_m][a];
                if (a == 0 || s > best_v) begin best_v = s; nxt = a; end
            end
        end
        lfsr_m = (lfsr_m >> 1) ^ (lfsr_m[0] ? 32'h8020_0003 : 32'd0);
        if (!warm) cum_m += total;                    // R3
        if (cnt_m < WU) cnt_m++;
        for (int c = 0; c < NC; c++) begin            // R4
            td = rew[c] + scale(qm[c][act_m][nxt], 58982) - qm[c][st_m][act_m];
            qm[c][st_m][act_m] = sat(qm[c][st_m][act_m] + scale(td, 6554));
        end
        st_m  = act_m;                                // R7
        act_m = nxt;
        exp_act.push_back(act_m);
        exp_cum.push_back(cum_m);
        pushes++;
    endtask

    task automatic drive_window(input int w, input bit extra);
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            tgt_vals[c*MW +: MW] = MW'(pick_t(w, c));
            obs_vals[c*MW +: MW] = MW'(pick_o(w, c));
        end
        win_done = 1'b1;
        model_step(w);
        @(negedge clk);
        win_done = 1'b0;
        // R9: scramble inputs while the sequence runs
        obs_vals = {NC{16'hBEEF}};
        tgt_vals = {NC{16'h1111}};
        @(negedge clk);
        check(busy == 1'b1, "R8 busy during sequence", busy, 1);
        if (extra) begin
            win_done = 1'b1;                          // R8: ignored strobe
            @(negedge clk);
            win_done = 1'b0;
        end
        repeat (20) @(negedge clk);
        check(busy == 1'b0, "R8 idle after sequence", busy, 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && act_done) begin
            dones++;
            if (exp_act.size() == 0) begin
                check(1'b0, "R8 unexpected done pulse", dones, pushes);
            end else begin
                int     ea;
                longint ec;
                ea = exp_act.pop_front();
                ec = exp_cum.pop_front();
                check(int'(act_sel) == ea, "R5/R6/R7 action", act_sel, ea);
                check(longint'(cum_reward) == ec, "R2/R3/R4 cumulative reward", cum_reward, ec);
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", dones, pushes);
        finish_run();
    end

    initial begin
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NA; s++)
                for (int a = 0; a < NA; a++) qm[c][s][a] = 0;
        st_m = 0; act_m = 0; cnt_m = 0; cum_m = 0;
        lfsr_m = SEEDB + 32'(AID);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(act_sel == 2'd0, "R1 reset action", act_sel, 0);
        check(cum_reward == 48'd0, "R1 reset cumulative", cum_reward, 0);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(act_done == 1'b0, "R1 reset done", act_done, 0);

        for (int w = 0; w < 14; w++)
            drive_window(w, (w == 5 || w == 9));

        repeat (5) @(negedge clk);
        check(exp_act.size() == 0, "R8 all results seen", exp_act.size(), 0);
        check(dones == pushes, "R8 done count", dones, pushes);
        finish_run();
    end
endmodule